// File: doc/BRIEF.md
# SAT Variable Cell Bank

This block holds the per-variable state of a hardware Boolean satisfiability solver. Each variable owns one cell that watches a three-wire line tuple (positive wire, negative wire, implied flag) shared with the clause array. A cell latches the decision level, the value and the assigned-or-implied origin of the first valid assignment or implication it sees. It also turns each rising implied flag into a single-cycle pulse, so the decision engine can wait until implications stop arriving.

During conflict analysis the engine raises an identify strobe. Every cell whose tuple then reads as a conflict-clause member registers a write strobe and offers the opposite polarity of its stored value as the literal for the learned clause. The registered members also drive a shared backtrack bus. Each member drives the bus as a wired-OR, and the bus is resolved from the most significant bit down so that it settles to the largest decision level among the members.

Top module: `satvar_bank`

## Requirements
- R1: While `rst` is high, and on the cycle after, every output is zero.
- R2: `new_impli[i]` is high for exactly one cycle, in the cycle that follows the first rising edge that samples `line_imp[i]` high after it was low (or after a clear), however long the flag stays high.
- R3: `clr[i]` clears both pulse-detector stages, so `new_impli[i]` is low in the next cycle. A flag still high after the clear is released yields one fresh pulse.
- R4: The tuple is written {pos,neg,imp}. For a cell whose `var_set` is low, an edge that samples tuple 100 (assigned 1) or 010 (assigned 0) sets `var_set` and stores `curr_lvl` and the value. It also clears `var_by_imp`.
- R5: For a cell whose `var_set` is low, tuple 101 (implied 1) or 011 (implied 0) stores the level and the value and sets `var_by_imp`.
- R6: While `var_set[i]` is high, every tuple (including 000, 001, 110 and 111) leaves the stored level, value and origin unchanged.
- R7: `clr[i]` returns the cell's stored level, value, origin and `var_set` to zero on the next edge.
- R8: An edge that samples `identify_cclause` high with tuple 110 sets `cc_wr[i]` in the next cycle. The literal is the opposite of the stored value: a stored 1 gives `cc_pos`=0, `cc_neg`=1, and a stored 0 gives `cc_pos`=1, `cc_neg`=0.
- R9: An edge that samples `identify_cclause` low, or any tuple other than 110, leaves `cc_wr[i]`, `cc_pos[i]` and `cc_neg[i]` at zero in the next cycle.
- R10: `bck_lvl` equals the largest stored level among the cells with `cc_wr` high, and zero when no cell has `cc_wr` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | NV | Per-cell clear from the decision engine |
| line_pos | input | NV | Positive wire of each variable tuple |
| line_neg | input | NV | Negative wire of each variable tuple |
| line_imp | input | NV | Implied flag of each variable tuple |
| curr_lvl | input | LW | Current decision level |
| identify_cclause | input | 1 | Conflict-analysis strobe |
| new_impli | output | NV | One-cycle implication pulse per cell |
| var_set | output | NV | Cell holds a value |
| var_val | output | NV | Stored value |
| var_by_imp | output | NV | Stored value came from an implication |
| var_lvl | output | NV*LW | Stored decision levels, cell i at bits i*LW upward |
| cc_wr | output | NV | Learned-clause write strobe per cell |
| cc_pos | output | NV | Learned literal positive wire |
| cc_neg | output | NV | Learned literal negative wire |
| bck_lvl | output | LW | Resolved backtrack level |

## Verification
On every cycle the assertions check the following: a pulse never lasts two cycles and always follows a sampled implied flag, a write strobe carries a one-hot literal and always follows the identify strobe, the bus is at least every member's level and is zero with no members, and a stored level holds while the cell stays set. Some properties need directed scenarios in the bench. These are that the bus equals the maximum and does not just bound it, that a clear re-arms the pulse while the flag stays high, and that the first tuple wins over later ones.

// File: rtl/satvar_pkg.sv
package satvar_pkg;

    typedef struct packed {
        logic pos;
        logic neg;
        logic imp;
    } line_t;

    typedef enum logic [2:0] {
        TUP_FREE     = 3'b000,
        TUP_BAD      = 3'b001,
        TUP_ASG0     = 3'b010,
        TUP_IMP0     = 3'b011,
        TUP_ASG1     = 3'b100,
        TUP_IMP1     = 3'b101,
        TUP_MEMBER   = 3'b110,
        TUP_CONFLICT = 3'b111
    } tuple_e;

    typedef struct packed {
        logic set;
        logic val;
        logic by_imp;
    } vstate_t;

    function automatic tuple_e classify(input line_t t);
        return tuple_e'(t);
    endfunction

    function automatic logic carries_value(input line_t t);
        return t.pos ^ t.neg;
    endfunction

endpackage

// File: rtl/satvar_pulse.sv
module satvar_pulse (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic imp_in,
    output logic pulse
);
    logic stage_a;
    logic stage_b;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stage_a <= 1'b0;
            stage_b <= 1'b0;
        end else begin
            stage_a <= imp_in;
            stage_b <= stage_a;
        end
    end

    assign pulse = stage_a & ~stage_b;
endmodule

// File: rtl/satvar_store.sv
module satvar_store
    import satvar_pkg::*;
#(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  line_t         tup,
    input  logic [LW-1:0] curr_lvl,
    output vstate_t       st,
    output logic [LW-1:0] lvl
);
    vstate_t st_q;
    logic [LW-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q  <= '0;
            lvl_q <= '0;
        end else if (!st_q.set && carries_value(tup)) begin
            st_q.set    <= 1'b1;
            st_q.val    <= tup.pos;
            st_q.by_imp <= tup.imp;
            lvl_q       <= curr_lvl;
        end
    end

    assign st  = st_q;
    assign lvl = lvl_q;
endmodule

// File: rtl/satvar_capture.sv
module satvar_capture
    import satvar_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  identify,
    input  line_t tup,
    input  logic  stored_val,
    output logic  wr,
    output logic  lit_pos,
    output logic  lit_neg
);
    logic member;

    assign member = identify && (classify(tup) == TUP_MEMBER);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr      <= 1'b0;
            lit_pos <= 1'b0;
            lit_neg <= 1'b0;
        end else begin
            wr      <= member;
            lit_pos <= member & ~stored_val;
            lit_neg <= member &  stored_val;
        end
    end
endmodule

// File: rtl/satvar_bckarb.sv
module satvar_bckarb #(
    parameter int NV = 4,
    parameter int LW = 4
) (
    input  logic [NV-1:0]    part,
    input  logic [NV*LW-1:0] lvls,
    output logic [LW-1:0]    bck
);
    logic [NV-1:0] alive;
    logic          bus_bit;

    always_comb begin
        alive   = part;
        bck     = '0;
        bus_bit = 1'b0;
        for (int k = LW - 1; k >= 0; k--) begin
            bus_bit = 1'b0;
            for (int c = 0; c < NV; c++) begin
                bus_bit = bus_bit | (alive[c] & lvls[c*LW + k]);
            end
            bck[k] = bus_bit;
            for (int c = 0; c < NV; c++) begin
                alive[c] = alive[c] & (lvls[c*LW + k] ~^ bus_bit);
            end
        end
    end
endmodule

// File: rtl/satvar_cell.sv
module satvar_cell
    import satvar_pkg::*;
#(
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  line_t         tup,
    input  logic [LW-1:0] curr_lvl,
    input  logic          identify,
    output logic          pulse,
    output vstate_t       st,
    output logic [LW-1:0] lvl,
    output logic          wr,
    output logic          lit_pos,
    output logic          lit_neg
);
    satvar_pulse u_pulse (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .imp_in (tup.imp),
        .pulse  (pulse)
    );

    satvar_store #(.LW(LW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .tup      (tup),
        .curr_lvl (curr_lvl),
        .st       (st),
        .lvl      (lvl)
    );

    satvar_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .identify   (identify),
        .tup        (tup),
        .stored_val (st.val),
        .wr         (wr),
        .lit_pos    (lit_pos),
        .lit_neg    (lit_neg)
    );
endmodule

// File: rtl/satvar_bank.sv
module satvar_bank
    import satvar_pkg::*;
#(
    parameter int NV = 4,
    parameter int LW = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NV-1:0]    clr,
    input  logic [NV-1:0]    line_pos,
    input  logic [NV-1:0]    line_neg,
    input  logic [NV-1:0]    line_imp,
    input  logic [LW-1:0]    curr_lvl,
    input  logic             identify_cclause,
    output logic [NV-1:0]    new_impli,
    output logic [NV-1:0]    var_set,
    output logic [NV-1:0]    var_val,
    output logic [NV-1:0]    var_by_imp,
    output logic [NV*LW-1:0] var_lvl,
    output logic [NV-1:0]    cc_wr,
    output logic [NV-1:0]    cc_pos,
    output logic [NV-1:0]    cc_neg,
    output logic [LW-1:0]    bck_lvl
);
    for (genvar i = 0; i < NV; i++) begin : g_cell
        line_t   tup;
        vstate_t st;

        assign tup.pos = line_pos[i];
        assign tup.neg = line_neg[i];
        assign tup.imp = line_imp[i];

        satvar_cell #(.LW(LW)) u_cell (
            .clk      (clk),
            .rst      (rst),
            .clr      (clr[i]),
            .tup      (tup),
            .curr_lvl (curr_lvl),
            .identify (identify_cclause),
            .pulse    (new_impli[i]),
            .st       (st),
            .lvl      (var_lvl[i*LW +: LW]),
            .wr       (cc_wr[i]),
            .lit_pos  (cc_pos[i]),
            .lit_neg  (cc_neg[i])
        );

        assign var_set[i]    = st.set;
        assign var_val[i]    = st.val;
        assign var_by_imp[i] = st.by_imp;
    end

    satvar_bckarb #(.NV(NV), .LW(LW)) u_arb (
        .part (cc_wr),
        .lvls (var_lvl),
        .bck  (bck_lvl)
    );
endmodule

// File: rtl/satvar_bank_chk.sv
module satvar_bank_chk #(
    parameter int NV = 4,
    parameter int LW = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [NV-1:0]    clr,
    input logic [NV-1:0]    line_imp,
    input logic             identify_cclause,
    input logic [NV-1:0]    new_impli,
    input logic [NV-1:0]    var_set,
    input logic [NV*LW-1:0] var_lvl,
    input logic [NV-1:0]    cc_wr,
    input logic [NV-1:0]    cc_pos,
    input logic [NV-1:0]    cc_neg,
    input logic [LW-1:0]    bck_lvl
);
    for (genvar i = 0; i < NV; i++) begin : g_chk
        a_r2_pulse_single: assert property (@(posedge clk) disable iff (rst)
            new_impli[i] |=> !new_impli[i]);

        a_r2_pulse_cause: assert property (@(posedge clk) disable iff (rst)
            new_impli[i] |-> $past(line_imp[i]));

        a_r8_onehot_literal: assert property (@(posedge clk) disable iff (rst)
            cc_wr[i] |-> (cc_pos[i] ^ cc_neg[i]));

        a_r10_bus_covers: assert property (@(posedge clk) disable iff (rst)
            cc_wr[i] |-> (bck_lvl >= var_lvl[i*LW +: LW]));

        a_r6_level_held: assert property (@(posedge clk) disable iff (rst)
            ($past(var_set[i]) && !$past(clr[i]) && !$past(rst))
                |-> $stable(var_lvl[i*LW +: LW]));
    end

    a_r8_needs_identify: assert property (@(posedge clk) disable iff (rst)
        (|cc_wr) |-> $past(identify_cclause));

    a_r10_idle_bus: assert property (@(posedge clk) disable iff (rst)
        (cc_wr == '0) |-> (bck_lvl == '0));
endmodule

bind satvar_bank satvar_bank_chk #(.NV(NV), .LW(LW)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .clr              (clr),
    .line_imp         (line_imp),
    .identify_cclause (identify_cclause),
    .new_impli        (new_impli),
    .var_set          (var_set),
    .var_lvl          (var_lvl),
    .cc_wr            (cc_wr),
    .cc_pos           (cc_pos),
    .cc_neg           (cc_neg),
    .bck_lvl          (bck_lvl)
);

// File: tb/tb_satvar_bank.sv
`timescale 1ns/1ps
module tb_satvar_bank;
    localparam int NV = 4;
    localparam int LW = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NV-1:0]    clr = '0;
    logic [NV-1:0]    line_pos = '0;
    logic [NV-1:0]    line_neg = '0;
    logic [NV-1:0]    line_imp = '0;
    logic [LW-1:0]    curr_lvl = '0;
    logic             identify_cclause = 1'b0;
    logic [NV-1:0]    new_impli, var_set, var_val, var_by_imp, cc_wr, cc_pos, cc_neg;
    logic [NV*LW-1:0] var_lvl;
    logic [LW-1:0]    bck_lvl;

    satvar_bank #(.NV(NV), .LW(LW)) dut (.*);

    always #2 clk = ~clk;

    // behavioural reference state
    logic          mA[NV], mB[NV], mset[NV], mval[NV], mimp[NV], mwr[NV], mpos[NV], mneg[NV];
    logic [LW-1:0] mlvl[NV];
    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string cur_req = "R1";

    initial begin
        for (int i = 0; i < NV; i++) begin
            mA[i] = 0; mB[i] = 0; mset[i] = 0; mval[i] = 0; mimp[i] = 0;
            mwr[i] = 0; mpos[i] = 0; mneg[i] = 0; mlvl[i] = '0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        for (int i = 0; i < NV; i++) begin
            if (rst || clr[i]) begin
                mA[i] = 0; mB[i] = 0; mset[i] = 0; mval[i] = 0; mimp[i] = 0;
                mwr[i] = 0; mpos[i] = 0; mneg[i] = 0; mlvl[i] = '0;
            end else begin
                logic member;
                member = identify_cclause && line_pos[i] && line_neg[i] && !line_imp[i];
                mwr[i]  = member;
                mpos[i] = member && (mval[i] == 1'b0);
                mneg[i] = member && (mval[i] == 1'b1);
                mB[i] = mA[i];
                mA[i] = line_imp[i];
                if (!mset[i] && (line_pos[i] != line_neg[i])) begin
                    mset[i] = 1; mval[i] = line_pos[i]; mimp[i] = line_imp[i]; mlvl[i] = curr_lvl;
                end
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int best;
        best = 0;
        for (int i = 0; i < NV; i++) begin
            chk($sformatf("new_impli[%0d]", i), int'(new_impli[i]), int'(mA[i] && !mB[i]));
            chk($sformatf("var_set[%0d]", i), int'(var_set[i]), int'(mset[i]));
            chk($sformatf("var_val[%0d]", i), int'(var_val[i]), int'(mval[i]));
            chk($sformatf("var_by_imp[%0d]", i), int'(var_by_imp[i]), int'(mimp[i]));
            chk($sformatf("var_lvl[%0d]", i), int'(var_lvl[i*LW +: LW]), int'(mlvl[i]));
            chk($sformatf("cc_wr[%0d]", i), int'(cc_wr[i]), int'(mwr[i]));
            chk($sformatf("cc_pos[%0d]", i), int'(cc_pos[i]), int'(mpos[i]));
            chk($sformatf("cc_neg[%0d]", i), int'(cc_neg[i]), int'(mneg[i]));
            if (mwr[i] && int'(mlvl[i]) > best) best = int'(mlvl[i]);
        end
        chk("bck_lvl", int'(bck_lvl), best);
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic set_tup(input int i, input logic [2:0] t);
        line_pos[i] = t[2];
        line_neg[i] = t[1];
        line_imp[i] = t[0];
    endtask

    initial begin : watchdog
        wait (cycles > 20000);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset
        cur_req = "R1";
        step(); step();
        chk("R1 outputs zero in reset", int'({new_impli, var_set, cc_wr, bck_lvl} != 0), 0);
        rst = 1'b0;
        step();

        // R4: assignments record level and value
        cur_req = "R4";
        curr_lvl = 4'd3; set_tup(0, 3'b100);
        curr_lvl = 4'd3;
        step();
        set_tup(0, 3'b000); curr_lvl = 4'd5; set_tup(1, 3'b010);
        step();
        set_tup(1, 3'b000);
        chk("R4 cell0 level", int'(var_lvl[0 +: LW]), 3);
        step();

        // R5 and R2: implication held for several cycles gives one pulse
        cur_req = "R5 R2";
        set_tup(2, 3'b101); curr_lvl = 4'd5;
        step(); step(); step(); step();
        set_tup(2, 3'b000); curr_lvl = 4'd7; set_tup(3, 3'b011);
        step(); step();
        set_tup(3, 3'b000);
        step(); step();

        // R6: set cells ignore later tuples
        cur_req = "R6";
        curr_lvl = 4'd9;
        set_tup(0, 3'b011); set_tup(1, 3'b111); set_tup(2, 3'b001); set_tup(3, 3'b110);
        step(); step();
        for (int i = 0; i < NV; i++) set_tup(i, 3'b000);
        step();

        // R8 and R10: learned clause members and backtrack maximum
        cur_req = "R8 R10";
        identify_cclause = 1'b1;
        set_tup(0, 3'b110); set_tup(1, 3'b110); set_tup(2, 3'b111); set_tup(3, 3'b110);
        step(); step();
        chk("R10 bus is max of 3,5,7", int'(bck_lvl), 7);
        chk("R8 cell0 stored 1 gives negative literal", int'({cc_pos[0], cc_neg[0]}), 1);
        chk("R8 cell1 stored 0 gives positive literal", int'({cc_pos[1], cc_neg[1]}), 2);
        set_tup(3, 3'b000);
        step();
        chk("R10 bus after cell3 leaves", int'(bck_lvl), 5);

        // R9: identify low or other tuple produces no write
        cur_req = "R9";
        identify_cclause = 1'b0;
        step();
        chk("R9 no write with identify low", int'(cc_wr), 0);
        identify_cclause = 1'b1;
        set_tup(0, 3'b111); set_tup(1, 3'b101);
        step();
        chk("R9 no write for non-member tuples", int'(cc_wr), 0);
        chk("R10 bus zero with no members", int'(bck_lvl), 0);
        identify_cclause = 1'b0;
        for (int i = 0; i < NV; i++) set_tup(i, 3'b000);
        step();

        // R3 and R7: clear re-arms the pulse and empties the store
        cur_req = "R3 R7";
        set_tup(2, 3'b101); curr_lvl = 4'd12;
        step(); step(); step();
        clr[2] = 1'b1;
        step();
        chk("R7 cell2 cleared", int'(var_set[2]), 0);
        chk("R3 no pulse after clear", int'(new_impli[2]), 0);
        clr[2] = 1'b0; curr_lvl = 4'd14;
        step();
        chk("R3 fresh pulse", int'(new_impli[2]), 1);
        chk("R5 relearned level", int'(var_lvl[2*LW +: LW]), 14);
        step();
        set_tup(2, 3'b000);
        clr = '1;
        step();
        clr = '0;
        step();

        // mixed traffic covering R2 R4 R5 R6 R8 R10
        cur_req = "mix R2 R4 R5 R6 R8 R10";
        for (int n = 0; n < 400; n++) begin
            curr_lvl = 4'($urandom_range(0, 15));
            identify_cclause = ($urandom_range(0, 2) == 0);
            for (int i = 0; i < NV; i++) begin
                set_tup(i, 3'($urandom_range(0, 7)));
                clr[i] = ($urandom_range(0, 15) == 0);
            end
            step();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule